// File: doc/BRIEF.md
# Barrel Shifter With Carry Output

This unit performs the shift and rotate work of a 32-bit processor's arithmetic stage. A request strobe gives it an operand, an unsigned shift count and an operation code. Four operations are available: logical left shift, logical right shift, arithmetic right shift and left rotate. Exactly one clock later it presents the result, a carry flag, a zero flag and a negative flag, with a one-cycle valid pulse.

The carry is defined as the last bit pushed out of the word, so it depends only on the bits that actually leave the word. The count is wider than five bits, so counts of 32 to 63 are distinct from small counts. Shifts by such a count saturate: the logical shifts give zero, and the arithmetic shift fills the word with copies of the sign. A rotate uses only the count modulo 32.

Top module: `barrel_shift_unit`

## Requirements
- R1: With op code 0 (logical left) and a count from 1 to 31, the result is the operand shifted left with zeros entering at bit 0, and the carry is operand bit (32 minus count).
- R2: With op code 1 (logical right) and a count from 1 to 31, the result is the operand shifted right with zeros entering at bit 31, and the carry is operand bit (count minus 1), whatever the higher operand bits hold.
- R3: With op code 2 (arithmetic right) and a count from 1 to 31, the vacated top bits take the operand's bit 31, and the carry is operand bit (count minus 1).
- R4: A logical right shift by 32 to 63 gives an all-zero result; the carry is operand bit 31 for a count of exactly 32 and 0 above it.
- R5: An arithmetic right shift by 32 to 63 gives a result in which every bit equals operand bit 31, and the carry equals operand bit 31.
- R6: A logical left shift by 32 to 63 gives an all-zero result; the carry is operand bit 0 for a count of exactly 32 and 0 above it.
- R7: With op code 3 (left rotate) the word turns left by the count modulo 32, bits leaving bit 31 entering at bit 0; the carry equals result bit 0, or 0 when the count modulo 32 is zero.
- R8: A count of zero on any shift returns the operand unchanged with the carry at 0.
- R9: The zero flag is 1 exactly when the presented result is all zeros, and the negative flag equals result bit 31.
- R10: The valid output is 1 in exactly the cycle after a request; without a request, result and flags hold their last values.
- R11: A synchronous reset forces valid to 0 in the following cycle, even if a request is present, and leaves the last result and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe; inputs are captured on this edge |
| op | input | 2 | Operation: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate left |
| opa | input | 32 | Operand |
| amt | input | 6 | Unsigned shift count, 0 to 63 |
| vld | output | 1 | Result valid, one cycle after req |
| res | output | 32 | Shifted or rotated result |
| carry | output | 1 | Last bit shifted out |
| zf | output | 1 | Result is zero |
| nf | output | 1 | Result bit 31 |

## Verification
Every operation is run on a grid of operands and counts. The single-bit operands 0x00000001 and 0x80000000 show whether the carry is taken from the right end, and 0x7FFFFFFF, 0xFFFFFFFF and 0xA5A5A5A5 show the sign fill and show any leak of high bits into the right-shift carry. The counts 0, 1, 5, 31, 32, 33 and 63 cover the pass-through case, the normal range, the exact-width edge where the carry is still a real bit, and saturation. A long random stream then runs with idle cycles between requests and with resets in the middle of the stream. This checks the one-cycle timing, that the outputs hold when no request arrives, and how reset takes priority over a request in the same cycle.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'd0,
    OP_LSR = 2'd1,
    OP_ASR = 2'd2,
    OP_ROL = 2'd3
  } shop_e;
endpackage

// File: rtl/shift_core.sv
module shift_core
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  shop_e          op,
  input  logic [W-1:0]   opa,
  input  logic [AW-1:0]  amt,
  output logic [W-1:0]   res,
  output logic           carry
);
  localparam int RW = $clog2(W);

  // Left shift in a word one bit wider: the extra top bit catches the last bit out.
  function automatic logic [W:0] shl_c(input logic [W-1:0] x, input logic [AW-1:0] a);
    logic [W:0] t;
    t = {1'b0, x} << a;
    return t;
  endfunction

  // Right shifts keep one guard bit below bit 0; it ends up holding the carry.
  function automatic logic [W:0] shr_c(input logic [W-1:0] x, input logic [AW-1:0] a,
                                       input logic arith);
    logic signed [W:0] s;
    logic [W:0]        t;
    s = $signed({x, 1'b0});
    if (arith) t = s >>> a;
    else       t = {x, 1'b0} >> a;
    return t;
  endfunction

  // Rotate by the count modulo W: carry is the bit landing in bit 0.
  function automatic logic [W:0] rol_c(input logic [W-1:0] x, input logic [RW-1:0] r);
    logic [2*W-1:0] d;
    logic [W-1:0]   y;
    d = {x, x} << r;
    y = d[2*W-1:W];
    return {y, (r != '0) & y[0]};
  endfunction

  logic [W:0] lsl_w, lsr_w, asr_w, rol_w;

  always_comb begin
    lsl_w = shl_c(opa, amt);
    lsr_w = shr_c(opa, amt, 1'b0);
    asr_w = shr_c(opa, amt, 1'b1);
    rol_w = rol_c(opa, amt[RW-1:0]);
    unique case (op)
      OP_LSL: begin res = lsl_w[W-1:0]; carry = lsl_w[W]; end
      OP_LSR: begin res = lsr_w[W:1];   carry = lsr_w[0]; end
      OP_ASR: begin res = asr_w[W:1];   carry = asr_w[0]; end
      default: begin res = rol_w[W:1];  carry = rol_w[0]; end
    endcase
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         zf,
  output logic         nf
);
  assign zf = (res == '0);
  assign nf = res[W-1];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [AW-1:0] amt,
  output logic          vld,
  output logic [W-1:0]  res,
  output logic          carry,
  output logic          zf,
  output logic          nf
);
  localparam int RW = $clog2(W);

  shop_e        op_e;
  logic [W-1:0] nxt_res;
  logic         nxt_carry, nxt_zf, nxt_nf;

  // Named events for the checks below.
  logic sat_shift, zero_amt, rot_zero;
  assign op_e      = shop_e'(op);
  assign sat_shift = (amt >= AW'(W));
  assign zero_amt  = (amt == '0);
  assign rot_zero  = (amt[RW-1:0] == '0);

  shift_core #(.W(W), .AW(AW)) u_core (
    .op(op_e), .opa(opa), .amt(amt), .res(nxt_res), .carry(nxt_carry)
  );

  flag_gen #(.W(W)) u_flags (.res(nxt_res), .zf(nxt_zf), .nf(nxt_nf));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else begin
      vld <= req;
      if (req) begin
        res   <= nxt_res;
        carry <= nxt_carry;
        zf    <= nxt_zf;
        nf    <= nxt_nf;
      end
    end
  end

  // R10
  valid_after_req_chk: assert property (@(posedge clk) disable iff (rst) req |=> vld);
  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst) !req |=> !vld);
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(res) && $stable(carry));
  // R4
  lsr_sat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    req && op_e == OP_LSR && sat_shift |=> res == '0);
  // R5
  asr_sat_fill_chk: assert property (@(posedge clk) disable iff (rst)
    req && op_e == OP_ASR && sat_shift |=> res == {W{$past(opa[W-1])}} && carry == $past(opa[W-1]));
  // R8
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req && zero_amt |=> res == $past(opa) && !carry);
  // R7
  rot_carry_chk: assert property (@(posedge clk) disable iff (rst)
    req && op_e == OP_ROL |=> carry == (!$past(rot_zero) && res[0]));
  // R9
  flags_chk: assert property (@(posedge clk) disable iff (rst)
    vld |-> (zf == (res == '0)) && (nf == res[W-1]));
endmodule

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op  = '0;
  logic [31:0] opa = '0;
  logic [5:0]  amt = '0;
  logic        vld, carry, zf, nf;
  logic [31:0] res;

  barrel_shift_unit dut (
    .clk(clk), .rst(rst), .req(req), .op(op), .opa(opa), .amt(amt),
    .vld(vld), .res(res), .carry(carry), .zf(zf), .nf(nf)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Model state: what outputs should read after the next edge.
  logic        e_vld = 1'b0;
  logic [31:0] e_res = '0;
  logic        e_c = 1'b0;
  bit          have_data = 0;
  string       e_tag = "R10";

  // Bit-at-a-time behavioural reference.
  task automatic ref_op(input int o, input int a, input logic [31:0] x,
                        output logic [31:0] r, output logic c);
    logic [31:0] y;
    y = x;
    c = 1'b0;
    if (o == 3) begin
      for (int i = 0; i < a % 32; i++) y = {y[30:0], y[31]};
      c = (a % 32 != 0) ? y[0] : 1'b0;
    end else begin
      for (int i = 0; i < a; i++) begin
        if (o == 0) begin c = y[31]; y = y << 1; end
        else if (o == 1) begin c = y[0]; y = y >> 1; end
        else begin c = y[0]; y = {y[31], y[31:1]}; end
      end
    end
    r = y;
  endtask

  function automatic string tag_of(input int o, input int a);
    if (a == 0 && o != 3) return "R8";
    case (o)
      0: return (a < 32) ? "R1" : "R6";
      1: return (a < 32) ? "R2" : "R4";
      2: return (a < 32) ? "R3" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: check previous expectation, then drive new inputs.
  task automatic step(input logic r_rst, input logic r_req, input int o, input int a,
                      input logic [31:0] x);
    logic [31:0] rr;
    logic        cc;
    @(negedge clk);
    chk((rst === 1'b1 || e_tag == "R11") ? "R11" : "R10", {31'b0, vld}, {31'b0, e_vld});
    if (have_data) begin
      chk(e_tag, res, e_res);
      chk(e_tag, {31'b0, carry}, {31'b0, e_c});
      chk("R9", {31'b0, zf}, {31'b0, (e_res == 32'b0)});
      chk("R9", {31'b0, nf}, {31'b0, e_res[31]});
    end
    rst = r_rst; req = r_req; op = 2'(o); amt = 6'(a); opa = x;
    if (r_rst) begin
      e_vld = 1'b0;
      e_tag = "R11";
    end else begin
      e_vld = r_req;
      if (r_req) begin
        ref_op(o, a, x, rr, cc);
        e_res = rr; e_c = cc; have_data = 1;
        e_tag = tag_of(o, a);
      end else begin
        e_tag = "R10";
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    int          amts [7];
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'hFFFF_FFFF; pats[4] = 32'hA5A5_A5A5;
    amts[0] = 0; amts[1] = 1; amts[2] = 5; amts[3] = 31;
    amts[4] = 32; amts[5] = 33; amts[6] = 63;

    // Reset state (R11): valid low while and after reset.
    e_vld = 1'b0; e_tag = "R11";
    step(1'b1, 1'b0, 0, 0, 32'h0);
    step(1'b1, 1'b0, 0, 0, 32'h0);
    step(1'b0, 1'b0, 0, 0, 32'h0);

    // Directed grid: R1..R9.
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 5; p++)
        for (int k = 0; k < 7; k++)
          step(1'b0, 1'b1, o, amts[k], pats[p]);
    step(1'b0, 1'b0, 0, 0, 32'h0);
    step(1'b0, 1'b0, 0, 0, 32'h0);   // R10 hold

    // R11: reset with a request present suppresses valid, data held.
    step(1'b0, 1'b1, 1, 4, 32'h1234_5678);
    step(1'b1, 1'b1, 0, 3, 32'hFFFF_0000);
    step(1'b0, 1'b0, 0, 0, 32'h0);

    // Random stream with idles and occasional resets (R10, R11).
    for (int i = 0; i < 3000; i++) begin
      int rv;
      rv = int'($urandom_range(0, 99));
      step(rv < 3, rv >= 25, int'($urandom_range(0, 3)), int'($urandom_range(0, 63)),
           32'($urandom));
    end
    step(1'b0, 1'b0, 0, 0, 32'h0);
    step(1'b0, 1'b0, 0, 0, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule